// File: doc/BRIEF.md
# Dual-Channel ATA Clock Source Switch Sequencer

Two ATA channels run from one shared bus clock. That clock comes from one of two sources: a PLL or the host bus clock. This block sits at the point where commands are issued. Each channel raises a one-cycle issue request together with a write flag. The block works out which source that command needs. Any write needs the PLL. When the host bus runs at the fast rate, every command needs the PLL. A read on a slow host bus needs the host bus clock.

If the command needs the source that is already selected, the block grants it straight away. If the command needs a change of source while the sibling channel still has a command outstanding, the block answers with a defer pulse, and the requester issues the command again later. Otherwise the block runs a five-step switch sequence and then grants the command:

1. Isolate both channel buses.
2. Drive the new select under a common channel reset.
3. Pulse the per-channel state-machine resets.
4. Release the common reset.
5. Reconnect both buses.

Each step holds for a parameterised number of clocks. The sequence never changes the channel enables: only enabled channels receive a state-machine reset pulse. While the block is sequencing, it defers every new request.

Top module: `ata_clksrc_sequencer`

## Requirements
- R1: A request with its write flag set requires the PLL source, which is encoded as clk_sel_o = 1. This holds whatever the level of fast_bus_i.
- R2: When fast_bus_i = 1, a read also requires the PLL. When fast_bus_i = 0, a read requires the host bus clock, encoded as clk_sel_o = 0.
- R3: If the required source equals the current source, the block pulses grant_o for the requesting channel in the cycle after the request. The bus controls stay idle: bus_tristate_o = 0, chan_reset_o = 0 and sm_reset_o = 0.
- R4: If a change of source is needed and chan_busy_i of the sibling channel is 1, the block pulses defer_o for the requesting channel in the cycle after the request. clk_sel_o does not change.
- R5: A switch runs five steps in a fixed order. ISOLATE: tristate both buses (bus_tristate_o = 11) with the old select. SWITCH: tristate, new select and chan_reset_o = 1. STATE-RESET: the same as SWITCH, plus the state-machine resets. RELEASE: tristate with chan_reset_o = 0. RECONNECT: bus_tristate_o = 00 with the new select.
- R6: Each step lasts exactly STEP_CYC clocks. The first step starts in the cycle after the request.
- R7: During the STATE-RESET step, sm_reset_o equals chan_en_i bit for bit. A disabled channel never receives a pulse, and the block drives no enable.
- R8: During reset and just after it, clk_sel_o = 1 (PLL), and all tristate, reset, grant and defer outputs are 0.
- R9: If both channels request in the same idle cycle, channel 0 is served. Channel 1 receives a defer pulse in the next cycle.
- R10: A request that arrives while a switch sequence or its grant cycle is in progress receives a defer pulse in the next cycle.
- R11: After RECONNECT, a switched request receives a one-cycle grant pulse, 5*STEP_CYC+1 cycles after the request. In that cycle the buses are connected, chan_reset_o = 0 and clk_sel_o already shows the new source, which it keeps afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_req_i | input | 2 | One-cycle issue request per channel (bit 0 = channel 0) |
| issue_wr_i | input | 2 | Write flag per channel, sampled with the request |
| chan_busy_i | input | 2 | Channel has a command outstanding |
| fast_bus_i | input | 1 | Host bus runs at the fast rate |
| chan_en_i | input | 2 | Channel enable bits |
| clk_sel_o | output | 1 | Clock source select: 1 = PLL, 0 = host bus clock |
| bus_tristate_o | output | 2 | Isolate each channel's bus |
| chan_reset_o | output | 1 | Common channel reset |
| sm_reset_o | output | 2 | Per-channel state-machine reset |
| grant_o | output | 2 | One-cycle grant pulse per channel |
| defer_o | output | 2 | One-cycle defer pulse per channel |

## Verification
The bench builds the block with STEP_CYC = 3. This keeps a full switch at 16 cycles, so every cycle of every sequence can be compared against the expected step outputs. It also brings step-boundary errors within reach: a step that ends one clock early or late shows up at once. The short sequence leaves room to run switches in both directions. These cover both fast-bus settings and three enable patterns (one channel, the other channel, neither). They also include a request placed in the middle of a sequence and a same-cycle collision of both channels.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  localparam int NCH = 2;

  localparam logic SRC_PLL = 1'b1;
  localparam logic SRC_BUS = 1'b0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISOLATE,
    ST_SWITCH,
    ST_SMRST,
    ST_RELEASE,
    ST_RECONNECT,
    ST_GRANT
  } seq_state_t;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_GRANT,
    ACT_DEFER,
    ACT_SWITCH
  } act_t;

  // Source a command needs: writes and fast-bus operation need the PLL
  function automatic logic required_src(input logic is_write, input logic fast_bus);
    return (is_write || fast_bus) ? SRC_PLL : SRC_BUS;
  endfunction

  function automatic logic sibling(input logic ch);
    return ~ch;
  endfunction

endpackage

// File: rtl/clksw_decide.sv
module clksw_decide
  import clksw_pkg::*;
(
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] wr_i,
  input  logic [NCH-1:0] busy_i,
  input  logic           fast_i,
  input  logic           cur_src_i,
  input  logic           idle_i,
  output act_t           act_o,
  output logic           win_ch_o,
  output logic           want_src_o,
  output logic [NCH-1:0] lose_defer_o
);

  always_comb begin
    win_ch_o     = req_i[0] ? 1'b0 : 1'b1;
    want_src_o   = required_src(wr_i[win_ch_o], fast_i);
    act_o        = ACT_NONE;
    lose_defer_o = '0;
    if (!idle_i) begin
      lose_defer_o = req_i;
    end else if (|req_i) begin
      lose_defer_o = {req_i[1] & req_i[0], 1'b0};
      if (want_src_o == cur_src_i)
        act_o = ACT_GRANT;
      else if (busy_i[sibling(win_ch_o)])
        act_o = ACT_DEFER;
      else
        act_o = ACT_SWITCH;
    end
  end

endmodule

// File: rtl/clksw_step_timer.sv
module clksw_step_timer #(
  parameter int STEP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int CW = (STEP_CYC < 2) ? 1 : $clog2(STEP_CYC);
  localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

  logic [CW-1:0] cnt;

  assign done_o = run_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (!run_i || done_o)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  // R6
  step_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R6
  step_cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt == '0));

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  act_t           act_i,
  input  logic           win_ch_i,
  input  logic           want_src_i,
  input  logic [NCH-1:0] lose_defer_i,
  input  logic           step_done_i,
  input  logic [NCH-1:0] chan_en_i,
  output logic           idle_o,
  output logic           seq_run_o,
  output logic           cur_src_o,
  output logic           clk_sel_o,
  output logic [NCH-1:0] tristate_o,
  output logic           common_rst_o,
  output logic [NCH-1:0] sm_rst_o,
  output logic [NCH-1:0] grant_o,
  output logic [NCH-1:0] defer_o
);

  seq_state_t     state;
  logic           owner;
  logic           new_src;
  logic           cur_src;
  logic [NCH-1:0] grant_q;
  logic [NCH-1:0] defer_q;
  logic [NCH-1:0] defer_nxt;

  assign idle_o    = (state == ST_IDLE);
  assign seq_run_o = state inside {ST_ISOLATE, ST_SWITCH, ST_SMRST, ST_RELEASE, ST_RECONNECT};
  assign cur_src_o = cur_src;

  always_comb begin
    defer_nxt = lose_defer_i;
    if (idle_o && act_i == ACT_DEFER)
      defer_nxt[win_ch_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      owner   <= 1'b0;
      new_src <= SRC_PLL;
      cur_src <= SRC_PLL;
      grant_q <= '0;
      defer_q <= '0;
    end else begin
      grant_q <= '0;
      defer_q <= defer_nxt;
      unique case (state)
        ST_IDLE: begin
          if (act_i == ACT_GRANT)
            grant_q[win_ch_i] <= 1'b1;
          else if (act_i == ACT_SWITCH) begin
            owner   <= win_ch_i;
            new_src <= want_src_i;
            state   <= ST_ISOLATE;
          end
        end
        ST_ISOLATE:   if (step_done_i) state <= ST_SWITCH;
        ST_SWITCH:    if (step_done_i) state <= ST_SMRST;
        ST_SMRST:     if (step_done_i) state <= ST_RELEASE;
        ST_RELEASE:   if (step_done_i) state <= ST_RECONNECT;
        ST_RECONNECT: begin
          if (step_done_i) begin
            state          <= ST_GRANT;
            cur_src        <= new_src;
            grant_q[owner] <= 1'b1;
          end
        end
        ST_GRANT:     state <= ST_IDLE;
        default:      state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tristate_o   = (state inside {ST_ISOLATE, ST_SWITCH, ST_SMRST, ST_RELEASE}) ? '1 : '0;
    common_rst_o = (state inside {ST_SWITCH, ST_SMRST});
    sm_rst_o     = (state == ST_SMRST) ? chan_en_i : '0;
    clk_sel_o    = (state inside {ST_SWITCH, ST_SMRST, ST_RELEASE, ST_RECONNECT}) ? new_src : cur_src;
  end

  assign grant_o = grant_q;
  assign defer_o = defer_q;

  // R5
  sel_change_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel_o) |-> (tristate_o == '1) && common_rst_o);

  // R5
  rst_under_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    common_rst_o |-> (tristate_o == '1));

  // R5
  smrst_inside_common_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_rst_o != '0) |-> common_rst_o);

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R11
  grant_bus_connected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> (tristate_o == '0) && !common_rst_o);

  // R4
  no_grant_and_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & defer_o) == '0);

endmodule

// File: rtl/ata_clksrc_sequencer.sv
module ata_clksrc_sequencer
  import clksw_pkg::*;
#(
  parameter int STEP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] issue_req_i,
  input  logic [1:0] issue_wr_i,
  input  logic [1:0] chan_busy_i,
  input  logic       fast_bus_i,
  input  logic [1:0] chan_en_i,
  output logic       clk_sel_o,
  output logic [1:0] bus_tristate_o,
  output logic       chan_reset_o,
  output logic [1:0] sm_reset_o,
  output logic [1:0] grant_o,
  output logic [1:0] defer_o
);

  act_t           act;
  logic           win_ch;
  logic           want_src;
  logic [NCH-1:0] lose_defer;
  logic           idle;
  logic           seq_run;
  logic           step_done;
  logic           cur_src;

  clksw_decide u_decide (
    .req_i        (issue_req_i),
    .wr_i         (issue_wr_i),
    .busy_i       (chan_busy_i),
    .fast_i       (fast_bus_i),
    .cur_src_i    (cur_src),
    .idle_i       (idle),
    .act_o        (act),
    .win_ch_o     (win_ch),
    .want_src_o   (want_src),
    .lose_defer_o (lose_defer)
  );

  clksw_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (seq_run),
    .done_o (step_done)
  );

  clksw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_i        (act),
    .win_ch_i     (win_ch),
    .want_src_i   (want_src),
    .lose_defer_i (lose_defer),
    .step_done_i  (step_done),
    .chan_en_i    (chan_en_i),
    .idle_o       (idle),
    .seq_run_o    (seq_run),
    .cur_src_o    (cur_src),
    .clk_sel_o    (clk_sel_o),
    .tristate_o   (bus_tristate_o),
    .common_rst_o (chan_reset_o),
    .sm_rst_o     (sm_reset_o),
    .grant_o      (grant_o),
    .defer_o      (defer_o)
  );

  // R10
  busy_seq_defers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && (issue_req_i != 2'b00)) |=> (defer_o == $past(issue_req_i)));

  // R9
  collision_ch1_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && issue_req_i == 2'b11) |=> defer_o[1] && !grant_o[1]);

endmodule

// File: tb/tb_ata_clksrc_sequencer.sv
module tb_ata_clksrc_sequencer;

  localparam int STEP = 3;
  localparam int SEQ  = 5 * STEP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] issue_req_i = 2'b00;
  logic [1:0] issue_wr_i = 2'b00;
  logic [1:0] chan_busy_i = 2'b00;
  logic       fast_bus_i = 1'b0;
  logic [1:0] chan_en_i = 2'b11;
  logic       clk_sel_o;
  logic [1:0] bus_tristate_o;
  logic       chan_reset_o;
  logic [1:0] sm_reset_o;
  logic [1:0] grant_o;
  logic [1:0] defer_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  int    q_ch[$];
  int    q_kind[$];
  int    q_stamp[$];
  string q_tag[$];

  ata_clksrc_sequencer #(.STEP_CYC(STEP)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_req_i    (issue_req_i),
    .issue_wr_i     (issue_wr_i),
    .chan_busy_i    (chan_busy_i),
    .fast_bus_i     (fast_bus_i),
    .chan_en_i      (chan_en_i),
    .clk_sel_o      (clk_sel_o),
    .bus_tristate_o (bus_tristate_o),
    .chan_reset_o   (chan_reset_o),
    .sm_reset_o     (sm_reset_o),
    .grant_o        (grant_o),
    .defer_o        (defer_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // kind 0 = grant, 1 = defer; offset counts cycles from the driving negedge
  task automatic push_exp(input int ch, input int kind, input int off, input string tag);
    q_ch.push_back(ch);
    q_kind.push_back(kind);
    q_stamp.push_back(cyc + off);
    q_tag.push_back(tag);
  endtask

  // Drives a one-cycle request; returns at the first negedge after the sampling edge
  task automatic issue(input logic [1:0] m, input logic [1:0] w,
                       input int c0, input int k0, input int o0, input string t0,
                       input int c1, input int k1, input int o1, input string t1);
    @(negedge clk);
    issue_req_i = m;
    issue_wr_i  = w;
    if (c0 >= 0) push_exp(c0, k0, o0, t0);
    if (c1 >= 0) push_exp(c1, k1, o1, t1);
    @(negedge clk);
    issue_req_i = 2'b00;
    issue_wr_i  = 2'b00;
  endtask

  // Called at the first negedge after the request; walks every sequence cycle
  task automatic check_seq(input logic [1:0] en, input logic new_src, input logic old_src);
    for (int n = 1; n <= SEQ; n++) begin
      int k;
      logic [5:0] exp_v;
      logic [5:0] act_v;
      k = (n - 1) / STEP;
      exp_v = {(k <= 3) ? 2'b11 : 2'b00,
               (k == 1 || k == 2),
               (k == 2) ? en : 2'b00,
               (k == 0) ? old_src : new_src};
      act_v = {bus_tristate_o, chan_reset_o, sm_reset_o, clk_sel_o};
      chk(act_v == exp_v, (k == 2) ? "R7" : ((n - 1) % STEP == 0 ? "R6" : "R5"),
          "sequence step {tri,rst,sm,sel}", int'(act_v), int'(exp_v));
      @(negedge clk);
    end
    chk(bus_tristate_o == 2'b00 && !chan_reset_o && clk_sel_o == new_src, "R11",
        "grant cycle controls {tri,rst,sel}",
        int'({bus_tristate_o, chan_reset_o, clk_sel_o}), int'({2'b00, 1'b0, new_src}));
    @(negedge clk);
    chk(grant_o == 2'b00, "R11", "grant lasts one cycle", int'(grant_o), 0);
    chk(clk_sel_o == new_src, "R11", "select holds new source", int'(clk_sel_o), int'(new_src));
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 2; k++) begin
          logic seen;
          int idx;
          seen = (k == 0) ? grant_o[c] : defer_o[c];
          idx = -1;
          if (seen) begin
            for (int i = 0; i < q_ch.size(); i++)
              if (idx < 0 && q_ch[i] == c && q_kind[i] == k && q_stamp[i] == cyc) idx = i;
            checks++;
            if (idx < 0) begin
              failures++;
              $display("FAIL %s unexpected %s on ch%0d at cycle %0d actual=1 expected=0",
                       (k == 0) ? "R11" : "R4", (k == 0) ? "grant" : "defer", c, cyc);
            end else begin
              q_ch.delete(idx);
              q_kind.delete(idx);
              q_stamp.delete(idx);
              q_tag.delete(idx);
            end
          end
        end
      end
      for (int i = q_ch.size() - 1; i >= 0; i--) begin
        if (q_stamp[i] < cyc) begin
          checks++;
          failures++;
          $display("FAIL %s missing %s on ch%0d actual=0 expected=1 at cycle %0d",
                   q_tag[i], (q_kind[i] == 0) ? "grant" : "defer", q_ch[i], q_stamp[i]);
          q_ch.delete(i);
          q_kind.delete(i);
          q_stamp.delete(i);
          q_tag.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL R11 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk({clk_sel_o, bus_tristate_o, chan_reset_o, sm_reset_o, grant_o, defer_o} == 10'h200,
        "R8", "reset outputs", int'({clk_sel_o, bus_tristate_o, chan_reset_o, sm_reset_o,
        grant_o, defer_o}), 'h200);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_sel_o == 1'b1 && bus_tristate_o == 2'b00, "R8", "after reset {sel,tri}",
        int'({clk_sel_o, bus_tristate_o}), 'h4);

    // R1, R3: write on slow bus, PLL already selected -> immediate grant
    issue(2'b01, 2'b01, 0, 0, 1, "R3", -1, 0, 0, "");
    chk(bus_tristate_o == 2'b00 && !chan_reset_o && sm_reset_o == 2'b00, "R3",
        "controls idle on direct grant", int'({bus_tristate_o, chan_reset_o, sm_reset_o}), 0);
    chk(clk_sel_o == 1'b1, "R1", "write keeps PLL", int'(clk_sel_o), 1);

    // R4: read needs bus clock, sibling busy -> defer, no change
    chan_busy_i = 2'b10;
    issue(2'b01, 2'b00, 0, 1, 1, "R4", -1, 0, 0, "");
    chk(clk_sel_o == 1'b1 && bus_tristate_o == 2'b00, "R4", "defer leaves source",
        int'({clk_sel_o, bus_tristate_o}), 'h4);
    chan_busy_i = 2'b00;

    // R2, R5, R6, R7, R10: read switches to bus clock; ch1 request mid-sequence
    chan_en_i = 2'b01;
    issue(2'b01, 2'b00, 0, 0, 1 + SEQ, "R5", -1, 0, 0, "");
    fork
      check_seq(2'b01, 1'b0, 1'b1);
      begin
        repeat (3) @(negedge clk);
        issue(2'b10, 2'b10, 1, 1, 1, "R10", -1, 0, 0, "");
      end
    join
    chk(clk_sel_o == 1'b0, "R2", "slow-bus read selects bus clock", int'(clk_sel_o), 0);

    // R1, R7: write on channel 1 from bus clock forces PLL; only ch1 enabled
    chan_en_i = 2'b10;
    issue(2'b10, 2'b10, 1, 0, 1 + SEQ, "R1", -1, 0, 0, "");
    check_seq(2'b10, 1'b1, 1'b0);

    // R2: fast bus read with PLL selected -> direct grant
    fast_bus_i = 1'b1;
    issue(2'b10, 2'b00, 1, 0, 1, "R2", -1, 0, 0, "");
    fast_bus_i = 1'b0;

    // R9: both channels request together, ch0 wins a switch, ch1 deferred
    chan_en_i = 2'b11;
    issue(2'b11, 2'b00, 0, 0, 1 + SEQ, "R9", 1, 1, 1, "R9");
    check_seq(2'b11, 1'b0, 1'b1);

    // R2, R4: fast bus read needs PLL; sibling busy defers first
    fast_bus_i  = 1'b1;
    chan_busy_i = 2'b01;
    issue(2'b10, 2'b00, 1, 1, 1, "R4", -1, 0, 0, "");
    chk(clk_sel_o == 1'b0, "R4", "deferred request leaves select", int'(clk_sel_o), 0);
    chan_busy_i = 2'b00;
    // R7: with both channels disabled no state-machine reset appears
    chan_en_i = 2'b00;
    issue(2'b10, 2'b00, 1, 0, 1 + SEQ, "R2", -1, 0, 0, "");
    check_seq(2'b00, 1'b1, 1'b0);

    repeat (3) @(negedge clk);
    chk(q_ch.size() == 0, "R11", "all expected responses seen", q_ch.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule